// File: doc/BRIEF.md
# Fractional-N Feedback Modulus Controller

This block chooses the divide modulus for the feedback divider of a fractional-N frequency synthesizer. It runs once per reference-clock cycle. Software supplies an integer divide value and the upper 21 bits of a 22-bit fraction. The block forces the lowest fraction bit to one, so the effective fraction is always odd. A 22-bit phase accumulator adds that fraction every cycle. On each cycle the block outputs the integer value, or that value plus one when the accumulator wraps. Over a long run the average divide ratio is the integer plus the fraction divided by 2^22.

Configuration is double-buffered. A write made while the accumulator is idle after reset takes effect at once. A later write is held and applied only after a cycle that produced the larger modulus, so one accumulator step never mixes an old integer with a new fraction.

A separate monitor counts feedback-divider edges over fixed windows of 1024 reference cycles. It raises a lock-lost flag when the count strays from 1024 by more than a tolerance. It lowers the flag again only after two good windows in a row.

Top module: `fracn_modctl`

## Requirements
- R1: After a synchronous reset, `modValid` and `lockLost` are 0, the accumulator is zero and no configuration is active, so `modValid` stays 0 until the first `cfgWrite`.
- R2: The effective fraction is `{cfgFrac, 1'b1}`: a `cfgFrac` of zero gives fraction 1, which never wraps within 2^22 − 1 steps, and an all-ones `cfgFrac` gives fraction 2^22 − 1.
- R3: Each running step adds the fraction to the accumulator modulo 2^22. One clock edge later, `modulus` shows N + 1 if that addition wrapped and N otherwise. The first step after a load starts from an accumulator of zero. The output is N_W+1 bits wide, so N = 255 with a wrap gives 256.
- R4: Over the first M steps after a load from idle, the number of N + 1 outputs is exactly floor(M·K / 2^22), where K is the effective fraction. Over 2^22 steps this is exactly K.
- R5: A `cfgWrite` made while idle loads N and the fraction at that edge. `modValid` rises one edge later.
- R6: A `cfgWrite` made while running, on a step that does not wrap, is held pending. It becomes active only after the next step that wraps; that wrapping step still uses the old values.
- R7: A `cfgWrite` that coincides with a wrapping step becomes active directly, and it discards any value already pending.
- R8: The lock window is 1024 reference cycles and is aligned to reset. At the end of each window, `lockLost` is set if |edges − 1024| > TOL (default 2). A difference of exactly TOL does not set it.
- R9: Once set, `lockLost` clears only at the end of the second consecutive in-tolerance window. A bad window in between restarts the count.
- R10: `lockLost` changes only at window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrite | input | 1 | Strobe that writes `cfgN` and `cfgFrac` |
| cfgN | input | N_W | Integer divide value N |
| cfgFrac | input | FRAC_W-1 | Fraction bits 21..1; bit 0 is forced to 1 |
| fbEdge | input | 1 | One per feedback-divider edge, synchronous to `clk` |
| modulus | output | N_W+1 | Divide modulus for the current step, N or N+1 |
| modValid | output | 1 | `modulus` is meaningful |
| lockLost | output | 1 | Feedback edge count out of tolerance |

## Verification
Two actions can fall in the same cycle: a configuration write, and an accumulator wrap that is also the boundary where pending values are applied. The bench keeps its own model of the accumulator, so it knows one edge ahead when a wrap will happen. It first leaves a value pending. It then issues a second write on exactly the wrapping step. The result is judged edge by edge: the wrapping step must still use the old N, and the second write, not the pending one, must govern every later modulus.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // Strobes issued by the sequencing control to the accumulator datapath
  typedef struct packed {
    logic step;       // advance accumulator, register a modulus
    logic loadCfg;    // copy port configuration into active registers
    logic applyPend;  // copy pending configuration into active registers
    logic loadPend;   // capture port configuration into pending registers
  } modStrobe_t;
endpackage

// File: rtl/fracn_accum.sv
module fracn_accum
  import fracn_pkg::*;
#(
  parameter int FRAC_W = 22,
  parameter int N_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  modStrobe_t       ctl,
  input  logic [N_W-1:0]   cfgN,
  input  logic [FRAC_W-2:0] cfgFrac,
  output logic             wrapNext,
  output logic [N_W:0]     modulus,
  output logic             modValid
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc, actK, pendK;
  logic [N_W-1:0]    actN, pendN;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    sum      = {1'b0, acc} + {1'b0, actK};
    wrapNext = sum[FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      actK     <= '0;
      actN     <= '0;
      pendK    <= '0;
      pendN    <= '0;
      modulus  <= '0;
      modValid <= 1'b0;
    end else begin
      modValid <= ctl.step;
      if (ctl.step) begin
        acc     <= sum[FRAC_W-1:0];
        modulus <= {1'b0, actN} + (N_W+1)'(sum[FRAC_W]);
      end
      if (ctl.loadCfg) begin
        actN <= cfgN;
        actK <= {cfgFrac, 1'b1};
      end else if (ctl.applyPend) begin
        actN <= pendN;
        actK <= pendK;
      end
      if (ctl.loadPend) begin
        pendN <= cfgN;
        pendK <= {cfgFrac, 1'b1};
      end
    end
  end

  // An active fraction is always odd while stepping
  assert_odd_frac_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.step |-> actK[0]);

  // No modulus is presented while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !ctl.step |=> !modValid);
endmodule

// File: rtl/fracn_ctrl.sv
module fracn_ctrl
  import fracn_pkg::*;
#(
  parameter int WIN = 1024,
  parameter int TOL = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgWrite,
  input  logic       wrapNext,
  input  logic       fbEdge,
  output modStrobe_t ctl,
  output logic       lockLost
);
  localparam int WW = $clog2(WIN);
  localparam int CW = WW + 1;

  logic running, pendValid, wrapNow;

  always_comb begin
    wrapNow       = running & wrapNext;
    ctl.step      = running;
    ctl.loadCfg   = cfgWrite & (~running | wrapNow);
    ctl.applyPend = wrapNow & pendValid & ~ctl.loadCfg;
    ctl.loadPend  = cfgWrite & running & ~wrapNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      pendValid <= 1'b0;
    end else begin
      if (cfgWrite) running <= 1'b1;
      if (ctl.loadPend) pendValid <= 1'b1;
      else if (ctl.loadCfg | ctl.applyPend) pendValid <= 1'b0;
    end
  end

  // Lock window monitor
  logic [WW-1:0] winCnt;
  logic [CW-1:0] fbCnt, total, diff;
  logic          winEnd, goodSeen, outTol;

  always_comb begin
    winEnd = (winCnt == WW'(WIN - 1));
    total  = fbCnt + CW'(fbEdge);
    diff   = (total > CW'(WIN)) ? total - CW'(WIN) : CW'(WIN) - total;
    outTol = diff > CW'(TOL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winCnt   <= '0;
      fbCnt    <= '0;
      lockLost <= 1'b0;
      goodSeen <= 1'b0;
    end else begin
      winCnt <= winEnd ? '0 : winCnt + 1'b1;
      fbCnt  <= winEnd ? '0 : total;
      if (winEnd) begin
        if (outTol) begin
          lockLost <= 1'b1;
          goodSeen <= 1'b0;
        end else if (lockLost) begin
          if (goodSeen) begin
            lockLost <= 1'b0;
            goodSeen <= 1'b0;
          end else begin
            goodSeen <= 1'b1;
          end
        end
      end
    end
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.loadCfg, ctl.applyPend, ctl.loadPend}));

  assert_pend_consumed_R7: assert property (@(posedge clk) disable iff (rst)
    (wrapNow && pendValid) |=> !pendValid);

  assert_flag_steady_R10: assert property (@(posedge clk) disable iff (rst)
    !winEnd |=> $stable(lockLost));

  assert_two_good_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(lockLost) |-> $past(goodSeen));
endmodule

// File: rtl/fracn_modctl.sv
module fracn_modctl
  import fracn_pkg::*;
#(
  parameter int FRAC_W = 22,
  parameter int N_W    = 8,
  parameter int WIN    = 1024,
  parameter int TOL    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWrite,
  input  logic [N_W-1:0]    cfgN,
  input  logic [FRAC_W-2:0] cfgFrac,
  input  logic              fbEdge,
  output logic [N_W:0]      modulus,
  output logic              modValid,
  output logic              lockLost
);
  modStrobe_t ctl;
  logic       wrapNext;

  fracn_ctrl #(.WIN(WIN), .TOL(TOL)) u_ctrl (
    .clk(clk), .rst(rst), .cfgWrite(cfgWrite), .wrapNext(wrapNext),
    .fbEdge(fbEdge), .ctl(ctl), .lockLost(lockLost)
  );

  fracn_accum #(.FRAC_W(FRAC_W), .N_W(N_W)) u_accum (
    .clk(clk), .rst(rst), .ctl(ctl), .cfgN(cfgN), .cfgFrac(cfgFrac),
    .wrapNext(wrapNext), .modulus(modulus), .modValid(modValid)
  );
endmodule

// File: tb/sim_fracn_modctl.sv
module sim_fracn_modctl;
  localparam int FW = 22;
  localparam int NW = 8;
  localparam longint FULL = 64'd1 << FW;

  logic clk = 1'b0, rst = 1'b1, cfgWrite = 1'b0, fbEdge = 1'b1;
  logic [NW-1:0] cfgN = '0;
  logic [FW-2:0] cfgFrac = '0;
  logic [NW:0] modulus;
  logic modValid, lockLost;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model state
  bit mRun, mPend;
  longint mAcc, mK, mN, pK, pN;
  int hits;

  fracn_modctl u0 (.clk(clk), .rst(rst), .cfgWrite(cfgWrite), .cfgN(cfgN),
    .cfgFrac(cfgFrac), .fbEdge(fbEdge), .modulus(modulus),
    .modValid(modValid), .lockLost(lockLost));

  always #4 clk = ~clk;

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit predictWrap();
    return mRun && (mAcc + mK >= FULL);
  endfunction

  task automatic doReset();
    rst = 1'b1; cfgWrite = 1'b0; fbEdge = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mRun = 0; mPend = 0; mAcc = 0; mK = 0; mN = 0; pK = 0; pN = 0;
  endtask

  // one reference step: drive at negedge, compare at the next negedge
  task automatic tick(bit wr, longint n, longint fr, string tag);
    bit c;
    longint expMod;
    bit expValid;
    cfgWrite = wr; cfgN = NW'(n); cfgFrac = (FW-1)'(fr);
    c = predictWrap();
    expValid = mRun;
    expMod = mN + (c ? 1 : 0);
    if (mRun) mAcc = (mAcc + mK) % FULL;
    if (wr && (!mRun || c)) begin
      mN = n; mK = fr * 2 + 1; mRun = 1; mPend = 0;
    end else begin
      if (c && mPend) begin mN = pN; mK = pK; mPend = 0; end
      if (wr) begin pN = n; pK = fr * 2 + 1; mPend = 1; end
    end
    @(negedge clk);
    cfgWrite = 1'b0;
    check({tag, " modValid"}, modValid, expValid);
    if (expValid) begin
      check({tag, " modulus"}, modulus, expMod);
      if (c) hits++;
    end
  endtask

  task automatic runWindow(int missing, bit prevFlag, bit expFlag, string tag);
    for (int i = 0; i < 1024; i++) begin
      fbEdge = (i >= missing);
      @(negedge clk);
      if (i == 511) check("R10 mid-window flag", lockLost, prevFlag);
    end
    check({tag, " window-end flag"}, lockLost, expFlag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint n, fr, k;
    void'($urandom(32'd1357));
    doReset();
    check("R1 modValid after reset", modValid, 0);
    check("R1 lockLost after reset", lockLost, 0);
    for (int i = 0; i < 3; i++) tick(0, 0, 0, "R1 idle");

    // R5 load from idle, R2 fraction 1 never wraps
    tick(1, 40, 0, "R5");
    for (int i = 0; i < 200; i++) tick(0, 0, 0, "R2 frac one");

    // R2 all-ones fraction wraps on every step but the first
    doReset();
    tick(1, 100, (1 << (FW - 1)) - 1, "R5");
    for (int i = 0; i < 50; i++) tick(0, 0, 0, "R2 all ones");

    // R3 / R4 random loads, one with N at its maximum
    for (int r = 0; r < 5; r++) begin
      doReset();
      n  = (r == 0) ? 255 : longint'($urandom_range(254, 0));
      fr = longint'($urandom_range((1 << (FW - 1)) - 1, 0));
      k  = fr * 2 + 1;
      tick(1, n, fr, "R5");
      hits = 0;
      for (int i = 0; i < 2000; i++) tick(0, 0, 0, "R3");
      check("R4 wrap count", hits, (2000 * k) / FULL);
    end

    // R6 write while running, on a non-wrapping step
    doReset();
    tick(1, 20, 21'h040000, "R5");
    while (predictWrap()) tick(0, 0, 0, "R3");
    tick(1, 30, 21'h0C0000, "R6 deferred write");
    for (int i = 0; i < 40; i++) tick(0, 0, 0, "R6");
    for (int i = 0; i < 400; i++) begin
      bit w = ($urandom_range(15, 0) == 0);
      tick(w, longint'($urandom_range(254, 0)),
           longint'($urandom_range((1 << (FW - 1)) - 1, (1 << (FW - 3)))), "R6 random");
    end

    // R7 write on a wrapping step supersedes pending
    doReset();
    tick(1, 50, 21'h050000, "R5");
    while (predictWrap()) tick(0, 0, 0, "R3");
    tick(1, 60, 21'h0F0000, "R7 pending");
    while (!predictWrap()) tick(0, 0, 0, "R7");
    tick(1, 70, 21'h033333, "R7 collide");
    for (int i = 0; i < 40; i++) tick(0, 0, 0, "R7");
    check("R7 active N", mN, 70);

    // lock monitor R8 / R9 / R10
    doReset();
    runWindow(0,    0, 0, "R8 clean");
    runWindow(2,    0, 0, "R8 at tolerance");
    runWindow(3,    0, 1, "R8 beyond tolerance");
    runWindow(0,    1, 1, "R9 first good");
    runWindow(5,    1, 1, "R9 bad restarts");
    runWindow(0,    1, 1, "R9 one good");
    runWindow(0,    1, 0, "R9 two good");
    runWindow(1000, 0, 1, "R8 large loss");
    doReset();
    check("R1 lockLost cleared", lockLost, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule